// File: doc/BRIEF.md
# Aliased Reset Control Register

This block holds the reset state of twenty hardware sub-blocks in one software-visible 32-bit register on a simple register bus. Every stored bit drives one active-low reset line: a stored 1 releases the matching sub-block, and a stored 0 holds it in reset. After a power-on or system reset every bit is zero, so every sub-block starts out held in reset.

The one storage register can be reached at four consecutive word addresses, and each address gives a write a different meaning. The first address replaces the whole register. The second turns on the bits whose write-data bit is 1. The third turns off the bits whose write-data bit is 1. The fourth discards the write. With the set and clear addresses, software can release or hold a single sub-block in one bus write, with no read-modify-write sequence that could race with another agent. Only the first address returns the register contents on a read. The upper twelve bits are reserved.

Top module: `rst_alias_ctrl`

## Requirements
- R1: While `rst_n` is low, and immediately after it goes high, every bit of `sub_rst_n_o` and of `rd_data` is 0.
- R2: A write to word address `BASE_WORD+0` (the load alias) sets the stored bits 19:0 to `wr_data[19:0]`.
- R3: A write to `BASE_WORD+1` (the set alias) forces to 1 every stored bit whose `wr_data` bit is 1. Stored bits whose `wr_data` bit is 0 keep their value.
- R4: A write to `BASE_WORD+2` (the clear alias) forces to 0 every stored bit whose `wr_data` bit is 1. Stored bits whose `wr_data` bit is 0 keep their value.
- R5: A write to `BASE_WORD+3` (the ignore alias) leaves every stored bit unchanged.
- R6: A write to any address outside `BASE_WORD..BASE_WORD+3` leaves every stored bit unchanged, and a read from such an address returns 0.
- R7: Bits 31:20 are reserved. Every write alias ignores them, and they always read as 0.
- R8: A read with `rd_en` high puts its result on `rd_data` in the next cycle. A read from `BASE_WORD+0` returns the stored value. A read from `BASE_WORD+1`, `+2` or `+3` returns 0. `rd_data` is 0 in any cycle that follows a cycle with no read.
- R9: A read issued in the same cycle as a write returns the stored value from before the write.
- R10: `sub_rst_n_o[i]` equals stored bit i and changes on the clock edge that accepts the write (1 = sub-block out of reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Word address of the access |
| wr_data | input | DATA_W | Write data or bit mask |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read result, valid the cycle after `rd_en` |
| sub_rst_n_o | output | NUM_RST | Active-low reset line for each sub-block |

## Verification
The bench builds the block with `ADDR_W=4` and `BASE_WORD=4`. Because the alias window then sits in the middle of the address space, the bench can reach addresses both below and above the window and check that writes there do nothing and reads there return zero. `DATA_W=32` and `NUM_RST=20` are kept, so the twelve reserved bits are present. The bench drives them with ones through every alias and checks that they never appear. A long random run mixes writes and reads to all four aliases in the same cycles, which exercises the rule that a read sees the value from before the write.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  // What a write does to the stored register this cycle
  typedef enum logic [2:0] {
    ACC_NONE  = 3'd0,
    ACC_LOAD  = 3'd1,
    ACC_SET   = 3'd2,
    ACC_CLEAR = 3'd3,
    ACC_DROP  = 3'd4
  } acc_kind_e;

  // Alias offsets inside the four-word window
  localparam logic [1:0] OFS_LOAD  = 2'd0;
  localparam logic [1:0] OFS_SET   = 2'd1;
  localparam logic [1:0] OFS_CLEAR = 2'd2;
  localparam logic [1:0] OFS_DROP  = 2'd3;

  // Next value of one stored bit, given the write data bit and kind
  function automatic logic bit_next(input logic cur, input logic din,
                                    input acc_kind_e kind);
    logic nxt;
    unique case (kind)
      ACC_LOAD:  nxt = din;
      ACC_SET:   nxt = cur | din;
      ACC_CLEAR: nxt = cur & ~din;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

  // Map an in-window offset to its write meaning
  function automatic acc_kind_e ofs_to_kind(input logic [1:0] ofs);
    acc_kind_e k;
    unique case (ofs)
      OFS_LOAD:  k = ACC_LOAD;
      OFS_SET:   k = ACC_SET;
      OFS_CLEAR: k = ACC_CLEAR;
      default:   k = ACC_DROP;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/rcr_decode.sv
module rcr_decode
  import rcr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BASE_WORD = 0
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         wr_kind,
  output logic              rd_load_alias
);

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_WORD);

  logic       in_window;
  logic [1:0] ofs;

  always_comb begin
    in_window = (addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
    ofs       = addr[1:0];
  end

  always_comb begin
    wr_kind = ACC_NONE;
    if (wr_en && in_window)
      wr_kind = ofs_to_kind(ofs);
  end

  assign rd_load_alias = rd_en && in_window && (ofs == OFS_LOAD);

endmodule

// File: rtl/rcr_bit_cell.sv
module rcr_bit_cell
  import rcr_pkg::*;
#(
  parameter bit IMPLEMENTED = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  acc_kind_e kind,
  input  logic      din,
  output logic      q
);

  logic nxt;

  always_comb begin
    nxt = bit_next(q, din, kind);
    if (!IMPLEMENTED)
      nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end

endmodule

// File: rtl/rcr_read_port.sv
module rcr_read_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] state,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_sel) rd_data <= state;
    else             rd_data <= '0;
  end

endmodule

// File: rtl/rst_alias_ctrl.sv
module rst_alias_ctrl
  import rcr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_RST   = 20,
  parameter int ADDR_W    = 4,
  parameter int BASE_WORD = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_RST-1:0] sub_rst_n_o
);

  // Named internal events, visible to the bound checker
  acc_kind_e         wr_kind;
  logic              rd_load_alias;
  logic [DATA_W-1:0] state;

  rcr_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_WORD (BASE_WORD)
  ) decode_i (
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .addr          (addr),
    .wr_kind       (wr_kind),
    .rd_load_alias (rd_load_alias)
  );

  // One cell per register bit; reserved cells stay at zero
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    rcr_bit_cell #(
      .IMPLEMENTED (b < NUM_RST)
    ) cell_i (
      .clk   (clk),
      .rst_n (rst_n),
      .kind  (wr_kind),
      .din   (wr_data[b]),
      .q     (state[b])
    );
  end

  rcr_read_port #(
    .DATA_W (DATA_W)
  ) rdport_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_sel  (rd_load_alias),
    .state   (state),
    .rd_data (rd_data)
  );

  // Stored 1 = sub-block released, so the bit is the active-low reset
  assign sub_rst_n_o = state[NUM_RST-1:0];

endmodule

// File: rtl/rcr_chk.sv
module rcr_chk #(
  parameter int DATA_W    = 32,
  parameter int NUM_RST   = 20,
  parameter int ADDR_W    = 4,
  parameter int BASE_WORD = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               rd_en,
  input logic [DATA_W-1:0]  rd_data,
  input logic [NUM_RST-1:0] sub_rst_n_o
);

  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(BASE_WORD);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(BASE_WORD + 1);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(BASE_WORD + 2);

  logic [NUM_RST-1:0] wmask;
  logic               changing_wr;
  assign wmask       = wr_data[NUM_RST-1:0];
  assign changing_wr = wr_en && (addr == A_LOAD || addr == A_SET || addr == A_CLEAR);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (sub_rst_n_o == '0 && rd_data == '0); // R1
    end
  end

  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LOAD) |=> sub_rst_n_o == $past(wmask)); // R2

  AST_SET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=>
      ((sub_rst_n_o & $past(wmask)) == $past(wmask)) &&
      ((sub_rst_n_o & ~$past(wmask)) == ($past(sub_rst_n_o) & ~$past(wmask)))); // R3

  AST_CLEAR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLEAR) |=>
      ((sub_rst_n_o & $past(wmask)) == '0) &&
      ((sub_rst_n_o & ~$past(wmask)) == ($past(sub_rst_n_o) & ~$past(wmask)))); // R4

  AST_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !changing_wr |=> $stable(sub_rst_n_o)); // R5 R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:NUM_RST] == '0); // R7

  AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_LOAD) |=> rd_data[NUM_RST-1:0] == $past(sub_rst_n_o)); // R9

  AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == A_LOAD) |=> rd_data == '0); // R8

endmodule

bind rst_alias_ctrl rcr_chk #(
  .DATA_W    (DATA_W),
  .NUM_RST   (NUM_RST),
  .ADDR_W    (ADDR_W),
  .BASE_WORD (BASE_WORD)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .addr        (addr),
  .wr_data     (wr_data),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .sub_rst_n_o (sub_rst_n_o)
);

// File: tb/rst_alias_ctrl_tb.sv
module rst_alias_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 32;
  localparam int NR   = 20;
  localparam int AW   = 4;
  localparam int BASE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic [NR-1:0] sub_rst_n_o;

  int vectors = 0;
  int miscompares = 0;

  // Behavioural reference: an integer image of the register
  longint unsigned model = 0;
  longint unsigned exp_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_alias_ctrl #(
    .DATA_W (DW), .NUM_RST (NR), .ADDR_W (AW), .BASE_WORD (BASE)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
    .wr_data (wr_data), .rd_en (rd_en), .rd_data (rd_data),
    .sub_rst_n_o (sub_rst_n_o)
  );

  function automatic longint unsigned impl_mask();
    return (64'd1 << NR) - 1;
  endfunction

  task automatic compare(input string tag, input longint unsigned got,
                         input longint unsigned want, input string what);
    vectors++;
    if (got != want) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
    end
  endtask

  // One bus cycle: drive at the falling edge, compare just after the rising edge
  task automatic bus(input string tag, input bit we, input int a,
                     input longint unsigned d, input bit re);
    longint unsigned m;
    @(negedge clk);
    wr_en = we; addr = AW'(a); wr_data = DW'(d); rd_en = re;
    @(posedge clk);
    #1;
    exp_rd = (re && a == BASE) ? model : 0;
    m = d & impl_mask();
    if (we) begin
      if (a == BASE)          model = m;
      else if (a == BASE + 1) model = model | m;
      else if (a == BASE + 2) model = model & ~m;
    end
    compare(tag, longint'(sub_rst_n_o), model, "sub_rst_n_o");
    compare(tag, longint'(rd_data), exp_rd, "rd_data");
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model = 0;
    compare("R1", longint'(sub_rst_n_o), 0, "sub_rst_n_o in reset");
    compare("R1", longint'(rd_data), 0, "rd_data in reset");
    @(negedge clk);
    rst_n = 1'b1;
    bus("R1", 1'b0, 0, 0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    do_reset();

    // R2 + R7: load all ones, reserved bits must drop
    bus("R2", 1'b1, BASE, 64'hFFFF_FFFF, 1'b0);
    bus("R7", 1'b0, 0, 0, 1'b1);
    bus("R7", 1'b0, BASE, 0, 1'b1);
    bus("R8", 1'b0, BASE, 0, 1'b0);
    bus("R2", 1'b1, BASE, 64'h000A_5A5A, 1'b0);
    // R8: aliases 1..3 read zero
    bus("R8", 1'b0, BASE + 1, 0, 1'b1);
    bus("R8", 1'b0, BASE + 2, 0, 1'b1);
    bus("R8", 1'b0, BASE + 3, 0, 1'b1);
    bus("R8", 1'b0, BASE, 0, 1'b1);
    // R3: set by mask, with reserved ones in the mask (R7)
    bus("R3", 1'b1, BASE + 1, 64'hFFF0_0101, 1'b0);
    bus("R3", 1'b1, BASE + 1, 64'h0008_0000, 1'b1);
    // R4: clear by mask
    bus("R4", 1'b1, BASE + 2, 64'h0000_00FF, 1'b0);
    bus("R4", 1'b1, BASE + 2, 64'hFFFF_0000, 1'b1);
    // R5: ignore alias
    bus("R2", 1'b1, BASE, 64'h000F_F00F, 1'b0);
    bus("R5", 1'b1, BASE + 3, 64'h0000_0000, 1'b0);
    bus("R5", 1'b1, BASE + 3, 64'hFFFF_FFFF, 1'b1);
    // R6: outside the window
    bus("R6", 1'b1, 0, 64'h0, 1'b0);
    bus("R6", 1'b1, 3, 64'hFFFF_FFFF, 1'b1);
    bus("R6", 1'b1, 8, 64'h0, 1'b1);
    bus("R6", 1'b1, 15, 64'h1234_5678, 1'b1);
    // R9: read in the same cycle as a write
    bus("R9", 1'b1, BASE, 64'h0001_2345, 1'b1);
    bus("R9", 1'b0, BASE, 0, 1'b1);
    bus("R9", 1'b1, BASE + 2, 64'h0001_0000, 1'b1);
    // R10: walk a single released sub-block across all lines
    bus("R10", 1'b1, BASE, 0, 1'b0);
    for (int i = 0; i < NR; i++) begin
      bus("R10", 1'b1, BASE + 1, 64'd1 << i, 1'b0);
      bus("R10", 1'b1, BASE + 2, 64'd1 << i, 1'b0);
    end
    // Mixed random traffic over all aliases and some outside addresses
    for (int n = 0; n < 400; n++) begin
      bus("R10", 1'(($urandom % 4) != 0), 2 + int'($urandom % 8),
          {32'd0, $urandom}, 1'($urandom % 2));
    end
    // R1: reset again from a populated state
    bus("R2", 1'b1, BASE, 64'h000F_FFFF, 1'b0);
    do_reset();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule